// File: doc/BRIEF.md
# Modbus RTU Frame Receiver

This block takes the byte stream from a UART receiver and cuts it into Modbus RTU frames. The only thing it uses to find frame edges is line silence. A counter measures the time since the last received byte in bit periods, using a baud-rate tick input. After reset, or after stray traffic, the block waits until the line has been quiet for a full inter-frame gap. Only then can the next byte open a frame. While a frame is being collected, a byte that arrives before the gap threshold is added to that frame. A silence that reaches the threshold closes the frame, and the byte after it is taken as the address of a new one.

As bytes arrive, the block stores them in one of two frame banks and updates a CRC-16 over them. When a frame closes, it looks at the first byte. If that byte is neither the configured station address nor the broadcast address, the frame is dropped without any report. A frame that is addressed to this station is judged on two things: its length and its CRC. A good frame goes downstream as a byte stream with start and end markers, with its two CRC bytes removed. A bad frame is reported as a single beat with the error marker set.

The inter-frame gap is 3.5 character times. With 11 bit periods per character, this is counted as 39 bit ticks. Because the banks alternate, the next frame can be collected while the previous one is still being read out.

Top module: `rtu_frame_rx`

## Requirements
- R1: After reset the block drops received bytes until the line has been silent for GAP_TICKS bit ticks. out_valid is 0 during and right after reset.
- R2: Silence is counted in `bit_tick` pulses since the last `rx_valid` byte. Once the count reaches GAP_TICKS (default 39), the next byte becomes byte 0 (the address) of a new frame.
- R3: A byte that arrives after fewer than GAP_TICKS ticks of silence is added to the open frame. This holds even when the sender intended it as a new message, so two merged frames are checked as one.
- R4: A silence of GAP_TICKS ticks closes the open frame. A partial frame cut off by such a gap is judged on its own and cannot pass the CRC, and the byte after the gap starts a new frame.
- R5: A frame is reported only if byte 0 equals `station_addr` or 0x00. Any other frame produces no output beat at all.
- R6: The CRC is the reflected polynomial 0xA001 with preset 0xFFFF. It is run over every byte of the frame, including the two CRC bytes (low byte first), and a frame is good only if the result is 0x0000.
- R7: A good frame with L bytes is output as L-2 beats: the address, the function code and the data, in arrival order. out_sof is set on the first beat, out_eof on the last, and out_err is 0.
- R8: A frame that fails the CRC, has fewer than 4 bytes, or has more than DEPTH bytes is output as exactly one beat with out_sof=out_eof=out_err=1 and out_data=0x00.
- R9: The beats of one frame come out on consecutive clock cycles with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period at the line baud rate |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| station_addr | input | 8 | Station address this receiver answers to |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8 | Output byte (0x00 on an error beat) |
| out_sof | output | 1 | First beat of a frame report |
| out_eof | output | 1 | Last beat of a frame report |
| out_err | output | 1 | Frame report is an error |

## Verification
The assertions assume three things about the inputs: `bit_tick` pulses at most once per clock, `rx_valid` is a single-cycle strobe, and real UART bytes arrive at least several ticks apart. Under these assumptions a new frame can never be completed while the last one is still being read out. The stimulus toggles `bit_tick` every other cycle and spaces bytes by whole tick counts. It keeps every gap clearly below or clearly above the 39-tick threshold (11, 30 and 37 ticks against 41 and 45), so a gap's classification never hinges on a one-tick rounding at the boundary. Every reported stream is checked against an expected list computed in the bench with its own CRC routine. The bench sweeps all frame lengths from 1 to DEPTH+3, a range of addresses, and single-bit corruptions of each byte.

// File: rtl/rtu_rx_pkg.sv
// Package: shared line states and the byte-wise CRC-16 step for the RTU
// frame receiver. Assumes reflected CRC, LSB of each byte processed first.
package rtu_rx_pkg;

    typedef enum logic [1:0] {
        LN_HUNT  = 2'd0,   // waiting for a first full silence
        LN_IDLE  = 2'd1,   // line quiet long enough, next byte opens a frame
        LN_FRAME = 2'd2    // collecting bytes of an open frame
    } line_state_e;

    localparam logic [15:0] CRC_POLY   = 16'hA001;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;

    // Advance the CRC by one whole byte, bit by bit, reflected form.
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] c;
        c = crc_in ^ {8'h00, data};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rtu_gap_timer.sv
// Silence timer: counts bit ticks since the last received byte and
// saturates at GAP_TICKS. gap_hit pulses on the tick that reaches it.
// Assumes bit_tick is at most one pulse per clock.
module rtu_gap_timer #(
    parameter int GAP_TICKS = 39
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic byte_seen,
    output logic gap_hit
);

    localparam int            CW       = $clog2(GAP_TICKS + 1);
    localparam logic [CW-1:0] LIMIT    = CW'(GAP_TICKS);
    localparam logic [CW-1:0] LIMIT_M1 = CW'(GAP_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks of silence; a byte restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (byte_seen) begin
            cnt_q <= '0;
        end else if (bit_tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Threshold reached on this tick with no byte in the same cycle.
    assign gap_hit = bit_tick && !byte_seen && (cnt_q == LIMIT_M1);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    p_byte_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_seen |=> (cnt_q == '0));

    p_hit_saturates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_hit |=> (cnt_q == LIMIT));

endmodule

// File: rtl/rtu_crc16.sv
// Running CRC-16 over the bytes of the open frame. start seeds the preset
// and folds in byte 0; step folds in each further byte.
// Assumes start and step never occur in the same cycle.
module rtu_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        step,
    input  logic [7:0]  data,
    output logic [15:0] crc_q
);

    import rtu_rx_pkg::*;

    // Update the remainder once per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET;
        end else if (start) begin
            crc_q <= crc16_byte(CRC_PRESET, data);
        end else if (step) begin
            crc_q <= crc16_byte(crc_q, data);
        end
    end

    p_start_step_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && step));

endmodule

// File: rtl/rtu_frame_buf.sv
// Two-bank frame store with readout engine. The writer fills one bank while
// the reader streams the other. launch either starts a readout of the
// closed bank (good frame) or emits a single error beat.
// Assumes a new launch only after the previous readout has ended.
module rtu_frame_buf #(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_bank,
    input  logic [$clog2(DEPTH)-1:0]  wr_idx,
    input  logic [7:0]                wr_data,
    input  logic                      launch,
    input  logic                      launch_good,
    input  logic                      launch_bank,
    input  logic [$clog2(DEPTH)-1:0]  launch_last,
    output logic                      out_valid,
    output logic [7:0]                out_data,
    output logic                      out_sof,
    output logic                      out_eof,
    output logic                      out_err
);

    localparam int IW      = $clog2(DEPTH);
    localparam int ENTRIES = 2 * DEPTH;
    localparam int AW      = $clog2(ENTRIES);

    logic [7:0]    mem_q [ENTRIES];
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          rd_active_q;
    logic          rd_bank_q;
    logic [IW-1:0] rd_idx_q;
    logic [IW-1:0] rd_last_q;

    assign wr_addr = wr_bank   ? (AW'(DEPTH) + AW'(wr_idx))   : AW'(wr_idx);
    assign rd_addr = rd_bank_q ? (AW'(DEPTH) + AW'(rd_idx_q)) : AW'(rd_idx_q);

    // Store each accepted byte into the writer's bank.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Readout engine and registered output beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active_q <= 1'b0;
            rd_bank_q   <= 1'b0;
            rd_idx_q    <= '0;
            rd_last_q   <= '0;
            out_valid   <= 1'b0;
            out_data    <= 8'h00;
            out_sof     <= 1'b0;
            out_eof     <= 1'b0;
            out_err     <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_err   <= 1'b0;
            if (launch) begin
                if (!launch_good) begin
                    out_valid <= 1'b1;
                    out_sof   <= 1'b1;
                    out_eof   <= 1'b1;
                    out_err   <= 1'b1;
                end else begin
                    rd_active_q <= 1'b1;
                    rd_bank_q   <= launch_bank;
                    rd_idx_q    <= '0;
                    rd_last_q   <= launch_last;
                end
            end else if (rd_active_q) begin
                out_valid <= 1'b1;
                out_data  <= mem_q[rd_addr];
                out_sof   <= (rd_idx_q == '0);
                out_eof   <= (rd_idx_q == rd_last_q);
                if (rd_idx_q == rd_last_q) begin
                    rd_active_q <= 1'b0;
                end else begin
                    rd_idx_q <= rd_idx_q + 1'b1;
                end
            end
        end
    end

    p_launch_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !rd_active_q);

    p_stream_unbroken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active_q && !launch) |=> out_valid);

    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_sof && out_eof && out_data == 8'h00));

    p_eof_then_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |=> (!out_valid || out_sof));

    p_err_only_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_sof || out_eof || out_err));

endmodule

// File: rtl/rtu_frame_rx.sv
// Modbus RTU frame receiver top. Frames are delimited only by silence of
// GAP_TICKS bit ticks. Byte 0 is matched against the station address or
// broadcast 0; matching frames are length- and CRC-checked and reported.
// Assumes DEPTH >= 4, DEPTH <= GAP_TICKS, bit_tick at most once per clock,
// rx_valid a one-cycle strobe per received byte.
module rtu_frame_rx #(
    parameter int DEPTH     = 16,
    parameter int GAP_TICKS = 39
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic [7:0] station_addr,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_err
);

    import rtu_rx_pkg::*;

    localparam int            IW        = $clog2(DEPTH);
    localparam int            LW        = $clog2(DEPTH + 2);
    localparam logic [LW-1:0] LEN_MIN   = LW'(4);
    localparam logic [LW-1:0] LEN_DEPTH = LW'(DEPTH);
    localparam logic [LW-1:0] LEN_OVER  = LW'(DEPTH + 1);

    line_state_e   state_q;
    logic [LW-1:0] len_q;
    logic          bank_q;
    logic          addr_ok_q;
    logic [15:0]   crc_q;
    logic          gap_hit;
    logic          frame_start;
    logic          frame_add;
    logic          frame_end;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic          launch;
    logic          launch_good;
    logic [IW-1:0] launch_last;

    rtu_gap_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .byte_seen (rx_valid),
        .gap_hit   (gap_hit)
    );

    // Byte events decoded against the line state.
    always_comb begin
        frame_start = (state_q == LN_IDLE)  && rx_valid;
        frame_add   = (state_q == LN_FRAME) && rx_valid;
        frame_end   = (state_q == LN_FRAME) && gap_hit;
    end

    // Line state: hunt for silence, wait idle, collect frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_HUNT;
        end else begin
            case (state_q)
                LN_HUNT:  if (gap_hit)  state_q <= LN_IDLE;
                LN_IDLE:  if (rx_valid) state_q <= LN_FRAME;
                LN_FRAME: if (gap_hit)  state_q <= LN_IDLE;
                default:                state_q <= LN_HUNT;
            endcase
        end
    end

    // Frame length (saturating one past DEPTH), address flag, bank toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q     <= '0;
            addr_ok_q <= 1'b0;
            bank_q    <= 1'b0;
        end else begin
            if (frame_start) begin
                len_q     <= LW'(1);
                addr_ok_q <= (rx_data == station_addr) || (rx_data == 8'h00);
            end else if (frame_add && (len_q != LEN_OVER)) begin
                len_q <= len_q + 1'b1;
            end
            if (frame_end) begin
                bank_q <= ~bank_q;
            end
        end
    end

    rtu_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (frame_start),
        .step  (frame_add),
        .data  (rx_data),
        .crc_q (crc_q)
    );

    // Buffer write and end-of-frame verdict.
    always_comb begin
        wr_en       = frame_start || (frame_add && (len_q < LEN_DEPTH));
        wr_idx      = frame_start ? '0 : IW'(len_q);
        launch      = frame_end && addr_ok_q;
        launch_good = (len_q >= LEN_MIN) && (len_q <= LEN_DEPTH) && (crc_q == 16'h0000);
        launch_last = IW'(len_q - LW'(3));
    end

    rtu_frame_buf #(.DEPTH(DEPTH)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_bank     (bank_q),
        .wr_idx      (wr_idx),
        .wr_data     (rx_data),
        .launch      (launch),
        .launch_good (launch_good),
        .launch_bank (bank_q),
        .launch_last (launch_last),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_sof     (out_sof),
        .out_eof     (out_eof),
        .out_err     (out_err)
    );

    p_hunt_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_HUNT && rx_valid) |=> (state_q == LN_HUNT));

    p_start_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state_q == LN_FRAME && len_q == LW'(1)));

    p_continue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_add |=> (state_q == LN_FRAME));

    p_gap_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (state_q == LN_IDLE));

    p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_OVER);

    p_drop_foreign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !addr_ok_q) |=> !out_valid);

endmodule

// File: tb/rtu_frame_rx_tb.sv
`timescale 1ns/1ps
module rtu_frame_rx_tb;

    localparam int DEPTH = 16;
    localparam int GAP   = 39;
    localparam logic [7:0] STATION = 8'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [7:0] station_addr = STATION;
    logic       out_valid, out_sof, out_eof, out_err;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    rtu_frame_rx #(.DEPTH(DEPTH), .GAP_TICKS(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_valid(rx_valid),
        .rx_data(rx_data), .station_addr(station_addr), .out_valid(out_valid),
        .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err)
    );

    always #10 clk = ~clk;

    always @(negedge clk) bit_tick <= ~bit_tick;

    // Output monitor
    longint     cyc = 0;
    logic [7:0] obs_d [4096];
    logic [2:0] obs_f [4096];
    longint     obs_c [4096];
    int         obs_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid && obs_n < 4096) begin
            obs_d[obs_n] <= out_data;
            obs_f[obs_n] <= {out_sof, out_eof, out_err};
            obs_c[obs_n] <= cyc;
            obs_n <= obs_n + 1;
        end
    end

    // Expected beat list
    logic [7:0] fb [32];
    logic [7:0] exp_d [256];
    logic [2:0] exp_f [256];
    int         exp_n = 0;
    int         mark  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_calc(input int s, input int len);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {8'h00, fb[s+i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c;
    endfunction

    // Fill fb[s..s+len-1]: address, data, CRC low/high when len >= 3.
    task automatic build(input int s, input logic [7:0] addr, input int len, input int seed);
        logic [15:0] c;
        fb[s] = addr;
        for (int i = 1; i < len; i++) fb[s+i] = 8'(seed * 37 + i * 13 + 5);
        if (len >= 3) begin
            c = crc_calc(s, len - 2);
            fb[s+len-2] = c[7:0];
            fb[s+len-1] = c[15:8];
        end
    endtask

    task automatic add_expected(input int s, input int len);
        if (fb[s] != STATION && fb[s] != 8'h00) return;
        if (len < 4 || len > DEPTH || crc_calc(s, len) != 16'h0000) begin
            exp_d[exp_n] = 8'h00; exp_f[exp_n] = 3'b111; exp_n++;
        end else begin
            for (int i = 0; i < len - 2; i++) begin
                exp_d[exp_n] = fb[s+i];
                exp_f[exp_n] = {(i == 0), (i == len - 3), 1'b0};
                exp_n++;
            end
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); rx_data = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic idle_ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic send(input int s, input int len, input int gap);
        for (int i = 0; i < len; i++) begin
            if (i > 0) idle_ticks(gap);
            put_byte(fb[s+i]);
        end
    endtask

    task automatic verify(input string req);
        int got;
        idle_ticks(GAP + 6);
        repeat (40) @(negedge clk);
        got = obs_n - mark;
        chk(got == exp_n, req, "beat count", got, exp_n);
        for (int i = 0; i < exp_n && i < got; i++) begin
            chk(obs_d[mark+i] == exp_d[i], req, "data", obs_d[mark+i], exp_d[i]);
            chk(obs_f[mark+i] == exp_f[i], req, "sof/eof/err", obs_f[mark+i], exp_f[i]);
            if (i > 0 && !exp_f[i][2])
                chk(obs_c[mark+i] == obs_c[mark+i-1] + 1, "R9", "beat spacing",
                    int'(obs_c[mark+i] - obs_c[mark+i-1]), 1);
        end
        mark  = obs_n;
        exp_n = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R1: a valid frame sent before the first full silence is dropped
        build(0, STATION, 6, 1);
        send(0, 6, 11);
        verify("R1");

        // R7 / R8: length sweep, station address
        for (int L = 1; L <= DEPTH + 3; L++) begin
            build(0, STATION, L, L);
            send(0, L, 11);
            add_expected(0, L);
            verify((L < 4 || L > DEPTH) ? "R8" : "R7");
        end

        // R5: broadcast accepted
        for (int L = 4; L <= 8; L++) begin
            build(0, 8'h00, L, L + 50);
            send(0, L, 11);
            add_expected(0, L);
            verify("R5");
        end

        // R5: foreign addresses dropped, good or bad CRC
        for (int k = 0; k < 6; k++) begin
            logic [7:0] a;
            a = (k == 0) ? 8'h01 : (k == 1) ? 8'h2B : (k == 2) ? 8'hAA :
                (k == 3) ? 8'hFF : (k == 4) ? 8'hAA : 8'h29;
            build(0, a, 6, k);
            if (k >= 4) fb[3] = fb[3] ^ 8'h10;
            send(0, 6, 11);
            add_expected(0, 6);
            chk(exp_n == 0, "R5", "bench expects drop", exp_n, 0);
            verify("R5");
        end

        // R6: single-bit corruption of every non-address byte
        for (int p = 1; p < 7; p++) begin
            build(0, STATION, 7, 9);
            fb[p] = fb[p] ^ (8'h01 << (p % 8));
            send(0, 7, 11);
            add_expected(0, 7);
            verify("R6");
        end

        // R3: slow but continuous frame stays one frame
        build(0, STATION, 8, 3);
        send(0, 8, 30);
        add_expected(0, 8);
        verify("R3");

        // R3: two frames 37 ticks apart merge into one checked frame
        build(0, STATION, 6, 4);
        build(6, STATION, 6, 5);
        send(0, 6, 11);
        idle_ticks(37);
        send(6, 6, 11);
        add_expected(0, 12);
        verify("R3");

        // R4 / R2: two frames 41 ticks apart are separate and both good
        build(0, STATION, 6, 6);
        build(6, STATION, 5, 7);
        send(0, 6, 11);
        idle_ticks(41);
        send(6, 5, 11);
        add_expected(0, 6);
        add_expected(6, 5);
        verify("R4");

        // R4: mid-frame gap cuts a frame; the partial is judged alone
        build(0, STATION, 8, 8);
        fb[4] = 8'h55;
        send(0, 4, 11);
        add_expected(0, 4);
        verify("R4");
        send(4, 4, 11);
        add_expected(4, 4);
        verify("R4");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule